// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block takes sixteen asynchronous interrupt pins from outside the chip and watches each one for a programmable trigger condition. When a line's condition is seen, the block records it in a pending bit. The pending bit stays set until software acknowledges it.

A per-line mask decides whether a pending line reaches the rest of the chip. Active lines (pending and unmasked) are merged into three grouped interrupt requests of unequal size, which feed a primary interrupt controller. On a grouped request, software reads the pending word to find the line that fired, handles it, and clears it by writing a one to its bit.

Trigger modes are programmed per pair of adjacent lines, so lines 2k and 2k+1 always use the same condition. Registers sit on a simple 32-bit word-addressed bus with a combinational read port.

Top module: `ext_irq_grouper`

## Requirements
- R1: At reset every mask bit is 1 (mask word reads 0xFFFF), the pending word reads 0, the trigger word reads 0 and all three group outputs are low.
- R2: The trigger word sits at byte offset 0x0. Lines n and n+1 (n even) share the 3-bit field at bits (n/2)*4+2 down to (n/2)*4, and bit (n/2)*4+3 of every slot reads 0 (writing all ones reads back 0x77777777).
- R3: Field value 100 or 101 selects rising edge. A low-to-high change on a pin, driven just after a clock edge, shows in the pending word after the third following rising clock edge and not after the second.
- R4: Field value 010 or 011 selects falling edge. Only a high-to-low change of the pin sets the pending bit.
- R5: Field value 110 or 111 selects both edges. Either change of the pin sets the pending bit.
- R6: Field value 000 selects low level and 001 selects high level. In level mode the pending bit is set on every cycle the condition holds, so a clear only takes effect once the pin is inactive.
- R7: The pending word at byte offset 0x8 is cleared by writing 1 to a bit position. Writing 0 leaves the bit unchanged. A set condition in the same cycle as a clear leaves the bit set.
- R8: The mask word at byte offset 0x4 holds one bit per line, with 1 masking the line. Pending bits still latch while the line is masked, and they reach the group output once the line is unmasked.
- R9: Group output 0 is the OR of active lines 0-3, output 1 of lines 4-11 and output 2 of lines 12-15, where a line is active when its pending bit is 1 and its mask bit is 0.
- R10: Byte offset 0xC reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 16 | Asynchronous external interrupt pins |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Byte address; bits 3:2 select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when not reading |
| grpIrq | output | 3 | Grouped interrupt requests (lines 0-3, 4-11, 12-15) |

## Verification
A pin change is taken by the first synchroniser flop at the next rising edge and by the second flop one edge later. The pending bit and the group output then follow on the third edge. Register writes take effect at the edge that ends the write cycle, and reads show the current state in the same cycle. The bench keeps a behavioural model that steps on the same edges, and it compares the group outputs and the read data 2 ns after every rising edge, so each result is checked in the exact cycle it is due. A few hand-computed checks pin down the three-edge latency and the clear-versus-level-held case.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Upper two bits of a trigger slot select the detection kind
  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_RISE  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trigKind_e;

  localparam int BUS_W = 32;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic             cfgWr;
    logic             maskWr;
    logic             pendClr;
    logic [BUS_W-1:0] data;
  } regStrobe_t;

endpackage

// File: rtl/extirq_regif.sv
module extirq_regif
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BUS_W-1:0]     busWdata,
  input  logic [BUS_W-1:0]     cfgWord,
  input  logic [NUM_LINES-1:0] maskVec,
  input  logic [NUM_LINES-1:0] pendVec,
  output regStrobe_t           stb,
  output logic [BUS_W-1:0]     busRdata
);

  localparam logic [1:0] IDX_CFG  = 2'd0;
  localparam logic [1:0] IDX_MASK = 2'd1;
  localparam logic [1:0] IDX_PEND = 2'd2;

  logic [1:0] wordIdx;
  logic       doWrite;
  logic       doRead;

  assign wordIdx = busAddr[3:2];
  assign doWrite = busSel & busWrite;
  assign doRead  = busSel & ~busWrite;

  always_comb begin
    stb         = '0;
    stb.data    = busWdata;
    stb.cfgWr   = doWrite && (wordIdx == IDX_CFG);
    stb.maskWr  = doWrite && (wordIdx == IDX_MASK);
    stb.pendClr = doWrite && (wordIdx == IDX_PEND);
  end

  always_comb begin
    busRdata = '0;
    if (doRead) begin
      case (wordIdx)
        IDX_CFG:  busRdata = cfgWord;
        IDX_MASK: busRdata = BUS_W'(maskVec);
        IDX_PEND: busRdata = BUS_W'(pendVec);
        default:  busRdata = '0;
      endcase
    end
  end

  // R10: a single access never reaches two registers
  always_comb begin
    a_r10_one_strobe : assert ($onehot0({stb.cfgWr, stb.maskWr, stb.pendClr}));
  end

endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int G0_LAST     = 3,
  parameter int G1_LAST     = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   pinIn,
  input  regStrobe_t             stb,
  output logic [NUM_LINES*2-1:0] cfgWord,
  output logic [NUM_LINES-1:0]   maskVec,
  output logic [NUM_LINES-1:0]   pendVec,
  output logic [2:0]             grpIrq
);

  localparam int NUM_PAIRS = NUM_LINES / 2;
  localparam int SLOT_W    = 4;
  localparam int MODE_W    = 3;

  // Input synchroniser
  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncQ;
  logic [NUM_LINES-1:0] pinNow;
  logic [NUM_LINES-1:0] pinPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      pinPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  // Trigger configuration, one slot per line pair
  logic [MODE_W-1:0] slotMode [NUM_PAIRS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PAIRS; p++) slotMode[p] <= '0;
    end else if (stb.cfgWr) begin
      for (int p = 0; p < NUM_PAIRS; p++)
        slotMode[p] <= stb.data[p*SLOT_W +: MODE_W];
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_slot
    assign cfgWord[p*SLOT_W +: SLOT_W] = {1'b0, slotMode[p]};
  end

  // Per-line detection
  logic [NUM_LINES-1:0] setVec;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    trigKind_e kind;
    logic      polHigh;
    logic      hit;
    assign kind    = trigKind_e'(slotMode[n/2][2:1]);
    assign polHigh = slotMode[n/2][0];
    always_comb begin
      case (kind)
        TRIG_LEVEL: hit = polHigh ? pinNow[n] : ~pinNow[n];
        TRIG_FALL:  hit = ~pinNow[n] & pinPrev[n];
        TRIG_RISE:  hit = pinNow[n] & ~pinPrev[n];
        default:    hit = pinNow[n] ^ pinPrev[n];
      endcase
    end
    assign setVec[n] = hit;
  end

  // Mask and pending
  logic [NUM_LINES-1:0] clrVec;
  assign clrVec = stb.pendClr ? stb.data[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskVec <= '1;
      pendVec <= '0;
    end else begin
      if (stb.maskWr) maskVec <= stb.data[NUM_LINES-1:0];
      pendVec <= (pendVec & ~clrVec) | setVec;
    end
  end

  // Grouping
  logic [NUM_LINES-1:0] activeVec;
  assign activeVec = pendVec & ~maskVec;
  assign grpIrq[0] = |activeVec[G0_LAST:0];
  assign grpIrq[1] = |activeVec[G1_LAST:G0_LAST+1];
  assign grpIrq[2] = |activeVec[NUM_LINES-1:G1_LAST+1];

  // R7: a written one clears the bit unless a set arrives in that cycle
  a_r7_w1c_clears : assert property (@(posedge clk) disable iff (!rstN)
    stb.pendClr |=> ((pendVec & $past(stb.data[NUM_LINES-1:0] & ~setVec)) == '0));

  // R7: without a clear, no pending bit falls
  a_r7_pend_sticky : assert property (@(posedge clk) disable iff (!rstN)
    !stb.pendClr |=> ((pendVec & $past(pendVec)) == $past(pendVec)));

  // R6: a pending bit only rises when its line detected the condition
  a_r6_set_has_cause : assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~$past(pendVec) & ~$past(setVec)) == '0));

  // R2: trigger word only moves on a write to it
  a_r2_cfg_stable : assert property (@(posedge clk) disable iff (!rstN)
    !stb.cfgWr |=> $stable(cfgWord));

  // R9: with every line masked no group request is raised
  a_r9_all_masked_quiet : assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '1) |-> (grpIrq == 3'b000));

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int G0_LAST     = 3,
  parameter int G1_LAST     = 11,
  parameter int ADDR_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [2:0]           grpIrq
);

  localparam int CFG_W = NUM_LINES * 2;

  regStrobe_t           stb;
  logic [CFG_W-1:0]     cfgWord;
  logic [NUM_LINES-1:0] maskVec;
  logic [NUM_LINES-1:0] pendVec;

  extirq_regif #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regif (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .cfgWord  (BUS_W'(cfgWord)),
    .maskVec  (maskVec),
    .pendVec  (pendVec),
    .stb      (stb),
    .busRdata (busRdata)
  );

  extirq_datapath #(
    .NUM_LINES   (NUM_LINES),
    .SYNC_STAGES (SYNC_STAGES),
    .G0_LAST     (G0_LAST),
    .G1_LAST     (G1_LAST)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .stb     (stb),
    .cfgWord (cfgWord),
    .maskVec (maskVec),
    .pendVec (pendVec),
    .grpIrq  (grpIrq)
  );

  // R1: all lines start masked
  a_r1_reset_masked : assert property (@(posedge clk)
    !rstN |=> (maskVec == '1) || rstN);

endmodule

// File: tb/test_ext_irq_grouper.sv
module test_ext_irq_grouper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pinIn = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  grpIrq;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  ext_irq_grouper i_ext_irq_grouper (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .grpIrq(grpIrq)
  );

  // Behavioural reference model
  bit       m1 [16];
  bit       m2 [16];
  bit       mPrev [16];
  bit [2:0] mSlot [8];
  bit       mMask [16];
  bit       mPend [16];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin
        m1[i] = 0; m2[i] = 0; mPrev[i] = 0; mMask[i] = 1; mPend[i] = 0;
      end
      for (int p = 0; p < 8; p++) mSlot[p] = 0;
    end else begin
      bit setB [16];
      for (int i = 0; i < 16; i++) begin
        bit [2:0] md;
        md = mSlot[i/2];
        if (md[2:1] == 2'b00)      setB[i] = md[0] ? m2[i] : !m2[i];
        else if (md[2:1] == 2'b01) setB[i] = !m2[i] && mPrev[i];
        else if (md[2:1] == 2'b10) setB[i] = m2[i] && !mPrev[i];
        else                       setB[i] = m2[i] != mPrev[i];
      end
      for (int i = 0; i < 16; i++) begin
        if (busSel && busWrite && busAddr[3:2] == 2 && busWdata[i]) mPend[i] = 0;
        if (setB[i]) mPend[i] = 1;
        mPrev[i] = m2[i]; m2[i] = m1[i]; m1[i] = pinIn[i];
        if (busSel && busWrite && busAddr[3:2] == 1) mMask[i] = busWdata[i];
      end
      if (busSel && busWrite && busAddr[3:2] == 0)
        for (int p = 0; p < 8; p++) mSlot[p] = busWdata[p*4 +: 3];
    end
  end

  function automatic logic [31:0] modelRead();
    logic [31:0] r = '0;
    if (busSel && !busWrite) begin
      for (int i = 0; i < 16; i++) begin
        if (busAddr[3:2] == 1) r[i] = mMask[i];
        if (busAddr[3:2] == 2) r[i] = mPend[i];
      end
      if (busAddr[3:2] == 0)
        for (int p = 0; p < 8; p++) r[p*4 +: 3] = mSlot[p];
    end
    return r;
  endfunction

  function automatic logic [2:0] modelGroups();
    logic [2:0] g = '0;
    for (int i = 0; i < 16; i++) begin
      if (mPend[i] && !mMask[i]) begin
        if (i <= 3) g[0] = 1;
        else if (i <= 11) g[1] = 1;
        else g[2] = 1;
      end
    end
    return g;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      check({curReq, " group"}, 32'(grpIrq), 32'(modelGroups()));
      check({curReq, " read"}, busRdata, modelRead());
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic setPin(int n, logic v);
    @(negedge clk);
    pinIn[n] = v;
  endtask

  initial begin
    logic [31:0] v;
    // R1: reset values, read while reset is held
    tick(2);
    rd(4'h4, v); check("R1 mask", v, 32'h0000FFFF);
    rd(4'h8, v); check("R1 pend", v, 32'h0);
    rd(4'h0, v); check("R1 cfg", v, 32'h0);
    check("R1 groups", 32'(grpIrq), 32'h0);
    busSel = 0;
    tick(1);
    rstN = 1;
    tick(3);

    // R2: slot layout and reserved bit
    curReq = "R2";
    wr(4'h0, 32'hFFFFFFFF);
    rd(4'h0, v); check("R2 cfg readback", v, 32'h77777777);
    busSel = 0;
    wr(4'h0, 32'h44444444);
    wr(4'h8, 32'h0000FFFF);
    wr(4'h4, 32'h0);
    rd(4'h8, v); check("R7 pend cleared", v, 32'h0);
    busSel = 0;

    // R3: rising edge latency
    curReq = "R3";
    setPin(0, 1);
    tick(2);
    rd(4'h8, v); check("R3 not yet after two edges", v, 32'h0);
    tick(1);
    rd(4'h8, v); check("R3 pending after three edges", v, 32'h1);
    check("R3 group0", 32'(grpIrq), 32'h1);
    busSel = 0;
    setPin(0, 0);
    tick(4);
    wr(4'h8, 32'h1);
    tick(3);

    // R4: falling edge on lines 4/5
    curReq = "R4";
    wr(4'h0, 32'h44444244);
    setPin(4, 1); tick(5);
    setPin(4, 0); tick(5);
    wr(4'h8, 32'h10); tick(2);

    // R5: both edges on lines 12/13
    curReq = "R5";
    wr(4'h0, 32'h46444244);
    setPin(12, 1); tick(5);
    wr(4'h8, 32'h1000); tick(2);
    setPin(12, 0); tick(5);
    wr(4'h8, 32'h1000); tick(2);

    // R6: high level on lines 2/3, low level on lines 14/15
    curReq = "R6";
    wr(4'h0, 32'h06444214);
    setPin(3, 1); tick(5);
    wr(4'h8, 32'h8); tick(1);
    rd(4'h8, v); check("R6 level held survives clear", v & 32'h8, 32'h8);
    busSel = 0;
    setPin(3, 0); tick(4);
    wr(4'h8, 32'hC000_0008 | 32'h0000C000); tick(1);
    rd(4'h8, v); check("R6 low level re-sets lines 14/15", v & 32'hC008, 32'hC000);
    busSel = 0;

    // R7: writing zeros leaves pending bits
    curReq = "R7";
    wr(4'h8, 32'h0); tick(2);
    wr(4'h0, 32'h44444444);
    wr(4'h8, 32'hFFFF); tick(2);

    // R8: masked lines still latch
    curReq = "R8";
    wr(4'h4, 32'hFFFF);
    setPin(1, 1); tick(4);
    rd(4'h8, v); check("R8 latched while masked", v & 32'h2, 32'h2);
    check("R8 group quiet while masked", 32'(grpIrq), 32'h0);
    busSel = 0;
    wr(4'h4, 32'h0); tick(1);
    check("R8 group after unmask", 32'(grpIrq), 32'h1);
    wr(4'h8, 32'hFFFF); tick(2);

    // R9: random traffic in both-edge mode
    curReq = "R9";
    wr(4'h0, 32'h66666666);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      pinIn = 16'($urandom);
      if (k % 7 == 3) begin
        busSel = 1; busWrite = 1; busAddr = 4'h8; busWdata = 32'($urandom);
      end else if (k % 11 == 5) begin
        busSel = 1; busWrite = 1; busAddr = 4'h4; busWdata = 32'($urandom);
      end else begin
        busSel = 1; busWrite = 0; busAddr = 4'((k % 3) * 4); busWdata = '0;
      end
    end
    @(negedge clk);
    busSel = 0; busWrite = 0;
    tick(3);

    // R10: unmapped word
    curReq = "R10";
    rd(4'hC, v); check("R10 unmapped read", v, 32'h0);
    busSel = 0;
    wr(4'hC, 32'hFFFFFFFF);
    rd(4'h0, v); check("R10 cfg untouched", v, 32'h66666666);
    busSel = 0;
    tick(3);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL all requirements: watchdog expired, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule